// File: doc/BRIEF.md
# Scanline-Compare Interrupt Unit

This block raises a CPU interrupt at a chosen rendered line of each video frame. The video side supplies a level that is high while a frame is being drawn and a one-cycle pulse at the start of each line. Inside the block a line counter runs during the frame. When the counter reaches a target line that software has programmed, a pending flag is latched.

The active-low interrupt output is driven low whenever the pending flag and an enable flag are both set. The pending flag is independent of the enable. It latches on a match even while the interrupt is masked, and only a read of the status register clears it. Software must therefore acknowledge by reading the status register. Dropping the enable only hides the request. If the enable is raised again while the request is still latched, the interrupt fires at once, with no new line match.

The CPU port is a plain address/data port with read and write strobes. The target register and the status/control register sit at two fixed addresses, and both addresses are parameters.

Top module: `scanline_irq_unit`

## Requirements
- R1: After reset, irq_n is 1, a status read returns 0x00, the enable flag is 0, the pending flag is 0, the target line is 0 and the line counter is 0.
- R2: A write to STATUS_ADDR (default 0x5204) sets the enable flag to data bit 7. The other data bits have no effect.
- R3: A write to TARGET_ADDR (default 0x5203) loads the 8-bit target line. While the target is 0, the pending flag is never set by the counter.
- R4: Line numbering works as follows while in_frame is high. The first line_start pulse of a frame makes the current line 0. Each later pulse advances the line by one, saturating at 255. The advance that makes the line equal the nonzero target sets the pending flag, whatever the enable flag holds.
- R5: irq_n is 0 exactly in the cycles after a clock edge that left both the pending flag and the enable flag set, and 1 otherwise.
- R6: Writing enable = 1 while the pending flag is already set drives irq_n low right after that write's clock edge, with no line_start pulse needed.
- R7: Writing enable = 0 returns irq_n to 1 after that edge, and the pending flag stays set. A later status read shows bit 7 = 1.
- R8: A read strobe at STATUS_ADDR returns, in the same cycle, bit 7 = pending flag and bit 6 = in-frame flag, with all other bits 0. The pending flag is cleared at that clock edge. Reads of any other address return 0 and change nothing.
- R9: If a status read and a target match occur in the same cycle, the pending flag is set after the edge.
- R10: When in_frame is low at a clock edge, the line counter and the in-frame flag clear. A frame sets the pending flag at most once for a given target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU register address |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rd | input | 1 | Read strobe, one cycle per access |
| cpu_wr | input | 1 | Write strobe, one cycle per access |
| cpu_rdata | output | 8 | Read data, valid in the strobe cycle |
| line_start | input | 1 | One-cycle pulse at the start of each rendered line |
| in_frame | input | 1 | High while the video side is rendering a frame |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
Each wrong internal state shows up at the ports within a few cycles.

- A pending flag that was lost or left stale appears on irq_n one cycle after the enable is written. It also appears in bit 7 of the next status read.
- An off-by-one in the line counter shifts the cycle in which irq_n falls by a whole line. The bench compares irq_n after every edge, so such a shift fails at the first affected line.
- A frame flag or counter that survives the end of a frame appears in bit 6 of a status read, or as a match in the wrong line of the next frame.

// File: rtl/slirq_pkg.sv
package slirq_pkg;
   // Status byte layout shared by the register block and its checks
   localparam int unsigned PEND_BIT  = 7;
   localparam int unsigned FRAME_BIT = 6;
   localparam int unsigned EN_BIT    = 7;

   typedef struct packed {
      logic pend;
      logic frame;
   } slirq_status_t;

   function automatic logic [7:0] pack_status(input slirq_status_t s);
      logic [7:0] v;
      v = '0;
      v[PEND_BIT]  = s.pend;
      v[FRAME_BIT] = s.frame;
      return v;
   endfunction
endpackage

// File: rtl/slirq_line_track.sv
module slirq_line_track #(
   parameter int unsigned LINE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              line_start,
   input  logic              in_frame,
   input  logic [LINE_W-1:0] target,
   output logic              match,
   output logic              frame_act,
   output logic [LINE_W-1:0] line_cnt
);
   localparam logic [LINE_W-1:0] CNT_MAX = {LINE_W{1'b1}};

   generate
      if (LINE_W < 2 || LINE_W > 16) begin : g_bad_w
         $error("slirq_line_track: LINE_W out of range");
      end
   endgenerate

   logic [LINE_W-1:0] cnt_next;

   always_comb begin
      cnt_next = (line_cnt == CNT_MAX) ? line_cnt : line_cnt + 1'b1;
      match    = frame_act && in_frame && line_start &&
                 (target != '0) && (line_cnt != CNT_MAX) && (cnt_next == target);
   end

   always_ff @(posedge clk) begin
      if (!rst_n || !in_frame) begin
         frame_act <= 1'b0;
         line_cnt  <= '0;
      end else if (line_start) begin
         if (!frame_act) begin
            frame_act <= 1'b1;
            line_cnt  <= '0;
         end else begin
            line_cnt  <= cnt_next;
         end
      end
   end

   // R10
   frame_end_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_frame |=> (line_cnt == '0) && !frame_act);

   // R3
   zero_target_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |-> (target != '0));

   // R4
   first_line_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && line_start && !frame_act) |=> (line_cnt == '0) && frame_act);
endmodule

// File: rtl/slirq_ctrl_regs.sv
module slirq_ctrl_regs
   import slirq_pkg::*;
#(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned LINE_W      = 8,
   parameter logic [ADDR_W-1:0] TARGET_ADDR = 16'h5203,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h5204
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              match,
   input  logic              frame_act,
   output logic [LINE_W-1:0] target,
   output logic              en_q,
   output logic              pend_q
);
   generate
      if (DATA_W < 8) begin : g_bad_dw
         $error("slirq_ctrl_regs: DATA_W must be at least 8");
      end
      if (LINE_W > DATA_W) begin : g_bad_lw
         $error("slirq_ctrl_regs: LINE_W must fit in DATA_W");
      end
      if (TARGET_ADDR == STATUS_ADDR) begin : g_bad_map
         $error("slirq_ctrl_regs: register addresses collide");
      end
   endgenerate

   logic wr_tgt, wr_stat, rd_stat;
   slirq_status_t stat;

   always_comb begin
      wr_tgt     = cpu_wr && (cpu_addr == TARGET_ADDR);
      wr_stat    = cpu_wr && (cpu_addr == STATUS_ADDR);
      rd_stat    = cpu_rd && (cpu_addr == STATUS_ADDR);
      stat.pend  = pend_q;
      stat.frame = frame_act;
      cpu_rdata  = '0;
      if (rd_stat) cpu_rdata[7:0] = pack_status(stat);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         target <= '0;
         en_q   <= 1'b0;
         pend_q <= 1'b0;
      end else begin
         if (wr_tgt)  target <= cpu_wdata[LINE_W-1:0];
         if (wr_stat) en_q   <= cpu_wdata[EN_BIT];
         if (match)        pend_q <= 1'b1;
         else if (rd_stat) pend_q <= 1'b0;
      end
   end

   // R4 R9
   match_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> pend_q);

   // R8
   ack_clears_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stat && !match) |=> !pend_q);

   // R2
   enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stat |=> (en_q == $past(cpu_wdata[EN_BIT])));

   // R7
   disable_keeps_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stat && !cpu_wdata[EN_BIT] && pend_q && !cpu_rd) |=> pend_q);
endmodule

// File: rtl/scanline_irq_unit.sv
module scanline_irq_unit #(
   parameter int unsigned ADDR_W      = 16,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned LINE_W      = 8,
   parameter logic [ADDR_W-1:0] TARGET_ADDR = 16'h5203,
   parameter logic [ADDR_W-1:0] STATUS_ADDR = 16'h5204,
   parameter bit IRQ_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [DATA_W-1:0] cpu_wdata,
   input  logic              cpu_rd,
   input  logic              cpu_wr,
   output logic [DATA_W-1:0] cpu_rdata,
   input  logic              line_start,
   input  logic              in_frame,
   output logic              irq_n
);
   logic              match, frame_act, en_q, pend_q;
   logic [LINE_W-1:0] line_cnt, target;

   slirq_line_track #(.LINE_W(LINE_W)) u_track (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .in_frame(in_frame),
      .target(target), .match(match), .frame_act(frame_act), .line_cnt(line_cnt)
   );

   slirq_ctrl_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_W(LINE_W),
      .TARGET_ADDR(TARGET_ADDR), .STATUS_ADDR(STATUS_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
      .match(match), .frame_act(frame_act),
      .target(target), .en_q(en_q), .pend_q(pend_q)
   );

   generate
      if (IRQ_REG) begin : g_irq_ff
         // Registered variant: one extra cycle of latency, glitch-free pin
         always_ff @(posedge clk) begin
            if (!rst_n) irq_n <= 1'b1;
            else        irq_n <= !(pend_q && en_q);
         end
      end else begin : g_irq_comb
         // Default variant: the pin follows the flag registers directly
         assign irq_n = !(pend_q && en_q);
      end
   endgenerate

   // R6
   reenable_fires_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!IRQ_REG && pend_q && $rose(en_q)) |-> !irq_n);

   // R1
   reset_irq_high_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> irq_n);
endmodule

// File: tb/sim_scanline_irq_unit.sv
module sim_scanline_irq_unit;
   localparam logic [15:0] TGT = 16'h5203;
   localparam logic [15:0] STA = 16'h5204;

   logic clk = 0, rst_n = 0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_wdata = '0, cpu_rdata;
   logic cpu_rd = 0, cpu_wr = 0, line_start = 0, in_frame = 0, irq_n;

   int n_chk = 0, n_fail = 0;

   // Reference state built from the requirements
   bit m_act, m_pend, m_en;
   int m_cnt, m_tgt;

   always #10 clk = ~clk;

   scanline_irq_unit u0 (.clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr),
      .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
      .line_start(line_start), .in_frame(in_frame), .irq_n(irq_n));

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int exp_rdata(bit rd, logic [15:0] a);
      return (rd && a == STA) ? ((int'(m_pend) << 7) | (int'(m_act) << 6)) : 0;
   endfunction

   function automatic bit exp_match(bit ls, bit inf);
      return m_act && inf && ls && m_tgt != 0 && m_cnt != 255 && (m_cnt + 1) == m_tgt;
   endfunction

   task automatic tick(input bit rd, input bit wr, input logic [15:0] a,
                       input logic [7:0] d, input bit ls, input bit inf, input string req);
      bit mt;
      @(negedge clk);
      cpu_rd = rd; cpu_wr = wr; cpu_addr = a; cpu_wdata = d;
      line_start = ls; in_frame = inf;
      #1;
      check({req, " R8 rdata"}, cpu_rdata, exp_rdata(rd, a));
      mt = exp_match(ls, inf);
      @(posedge clk);
      if (mt) m_pend = 1;
      else if (rd && a == STA) m_pend = 0;
      if (wr && a == STA) m_en = d[7];
      if (wr && a == TGT) m_tgt = d;
      if (!inf) begin m_act = 0; m_cnt = 0; end
      else if (ls) begin
         if (!m_act) begin m_act = 1; m_cnt = 0; end
         else if (m_cnt != 255) m_cnt++;
      end
      #1;
      check({req, " R5 irq_n"}, irq_n, !(m_pend && m_en));
   endtask

   task automatic idle(input bit inf, input string req);
      tick(0, 0, 16'h0000, 8'h00, 0, inf, req);
   endtask

   task automatic line(input string req);
      tick(0, 0, 16'h0000, 8'h00, 1, 1, req);
      idle(1, req);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin : main
      int k;
      void'($urandom(32'h5CA1));
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      m_act = 0; m_pend = 0; m_en = 0; m_cnt = 0; m_tgt = 0;
      // R1: reset state
      check("R1 irq_n", irq_n, 1);
      tick(1, 0, STA, 8'h00, 0, 0, "R1 status");

      // R3: target 0 never matches across a full frame
      idle(1, "R3");
      for (int i = 0; i < 300; i++) line("R3 zero target");
      tick(1, 0, STA, 8'h00, 0, 1, "R3 status");
      check("R3 pending clear", m_pend, 0);
      idle(0, "R10 frame end");
      tick(1, 0, STA, 8'h00, 0, 0, "R10 frame flag low");

      // R4: match with enable off sets pending only
      tick(0, 1, TGT, 8'd5, 0, 0, "R3 write target");
      for (int i = 0; i < 8; i++) line("R4 masked match");
      check("R4 irq masked", irq_n, 1);
      // R6: enable while pending fires at once
      tick(0, 1, STA, 8'h80, 0, 1, "R6 enable");
      check("R6 irq low", irq_n, 0);
      // R7: disable hides irq, pending stays
      tick(0, 1, STA, 8'h7F, 0, 1, "R7 disable");
      check("R7 irq high", irq_n, 1);
      tick(1, 0, STA, 8'h00, 0, 1, "R7 pending kept");
      check("R8 cleared", m_pend, 0);
      // R2: other bits do not enable
      tick(0, 1, STA, 8'h7F, 0, 1, "R2 low bits");
      check("R2 enable off", irq_n, 1);
      // R8: other address read gives 0
      tick(1, 0, 16'h5205, 8'h00, 0, 1, "R8 other addr");
      // R10: no second match in frame after saturating
      for (int i = 0; i < 260; i++) line("R10 saturate");
      tick(1, 0, STA, 8'h00, 0, 1, "R10 once per frame");
      idle(0, "R10");

      // R9: read in the same cycle as the match
      tick(0, 1, STA, 8'h80, 0, 0, "R9 enable");
      tick(0, 1, TGT, 8'd3, 0, 0, "R9 target");
      line("R9 line0"); line("R9 line1"); line("R9 line2");
      tick(1, 0, STA, 8'h00, 1, 1, "R9 read+match");
      check("R9 pending wins", irq_n, 0);
      tick(1, 0, STA, 8'h00, 0, 1, "R9 ack");
      check("R9 acked", irq_n, 1);
      idle(0, "R9");

      // Random frames mixing CPU traffic with line pulses
      for (int f = 0; f < 40; f++) begin
         tick(0, 1, TGT, 8'($urandom_range(0, 40)), 0, 0, "rand target");
         for (int c = 0; c < 400; c++) begin
            k = $urandom_range(0, 15);
            case (k)
               0: tick(1, 0, STA, 8'h00, $urandom_range(0, 1) == 1, 1, "rand read");
               1: tick(0, 1, STA, 8'($urandom), 0, 1, "rand en");
               2: tick(1, 0, TGT, 8'h00, 0, 1, "rand rd tgt");
               3, 4, 5: tick(0, 0, 16'h0, 8'h0, 1, 1, "rand line");
               default: idle(1, "rand idle");
            endcase
         end
         idle(0, "rand frame end");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule